// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler

This block produces clock-enable strobes for four synchronous domains that share one main clock: the processor domain, the high-speed bus domain and two peripheral bus domains (A and B). The main clock is one of two candidate tick inputs, an oscillator tick or a PLL tick, picked by a software-controlled source bit. A domain either runs at the full main rate or passes through a power-of-two prescaler. One free-running counter of selected main ticks drives all four prescalers, so the domains stay phase-aligned.

Each domain has a module mask. Every mask bit is ANDed with that domain's tick to give a per-module enable strobe, so software can turn individual module clocks on and off. Software reaches the source bit, the prescaler fields, the masks and a sticky error flag through a plain single-cycle register port. Writes act at the clock edge and read data is combinational from the address. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. A prescaler write that would make a child domain faster than its parent is refused.

Top module: `busclk_prescaler`

## Requirements
- R1: After reset the source bit reads 0 (oscillator), the prescaler register reads 0, all four masks read 0 and the error flag reads 0.
- R2: Address 0 bit 0 selects the main tick: 0 takes `osc_tick`, 1 takes `pll_tick`. No domain tick is raised in a cycle where the selected input is low.
- R3: A domain whose divide-enable bit is 0 ticks on every main tick.
- R4: A domain whose divide-enable bit is 1 with select value s ticks on a main tick exactly when the number of main ticks since reset, modulo 2^(s+1), is zero. The prescaler register at address 1 holds one 4-bit field per domain: domain d (0 processor, 1 high-speed bus, 2 peripheral A, 3 peripheral B) uses bits [4d+2:4d] as select and bit 4d+3 as divide-enable.
- R5: Let a domain's shift be 0 when its divide is disabled, else select+1. A write to address 1 is refused unless shift(0) <= shift(1) <= shift(2) and shift(1) <= shift(3). A refused write leaves the register unchanged and sets the error flag.
- R6: The error flag (address 2 bit 0) stays set until a write to address 2 with bit 0 = 1 clears it. A write there with bit 0 = 0 has no effect.
- R7: An accepted prescaler value reads back at once. It takes effect on the tick pattern only after the next main tick at which the main-tick count modulo 256 is zero.
- R8: For domain d, address 4+d writes its whole mask, address 8+d sets the mask bits where the data bit is 1, and address 12+d clears the mask bits where the data bit is 1. Other bits and other masks are unchanged. Addresses 4+d, 8+d and 12+d all read mask d. Address 3 reads 0 and writes to it are ignored.
- R9: Module enable n of domain d (`mod_en[8d+n]`) equals that domain's tick ANDed with mask d bit n.
- R10: Whenever the high-speed bus domain ticks, the processor domain ticks too. Whenever either peripheral domain ticks, the high-speed bus domain ticks too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator main-clock candidate tick |
| pll_tick | input | 1 | PLL main-clock candidate tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| dom_tick | output | 4 | Domain tick strobes, bit d is domain d |
| mod_en | output | 32 | Per-module enable strobes, 8 per domain |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
The hardest situation to reach from the ports is a prescaler change taking effect. A new setting is applied only at the alignment point, which comes once every 256 selected main ticks. So a written value has to sit unapplied and still read back correctly for hundreds of cycles, and it may be overwritten or refused in the meantime. The stimulus reaches this point on purpose by holding the selected tick high for 600 cycles after each directed write, one run using the largest select value. A long random phase then interleaves register writes, including illegal orderings, with sparse ticks from both sources, so that pending updates cross alignment points while the source is being switched.

// File: rtl/bcp_pkg.sv
`timescale 1ns/1ps
package bcp_pkg;
  localparam int NDOM   = 4;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    DOM_CPU = 2'd0,
    DOM_HSB = 2'd1,
    DOM_PBA = 2'd2,
    DOM_PBB = 2'd3
  } dom_e;

  localparam logic [ADDR_W-1:0] A_SRC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
  localparam logic [ADDR_W-1:0] A_ERR   = 4'd2;
  localparam logic [ADDR_W-1:0] A_RSVD  = 4'd3;

  // upper two address bits pick the mask operation
  localparam logic [1:0] MOP_WR  = 2'd1;
  localparam logic [1:0] MOP_SET = 2'd2;
  localparam logic [1:0] MOP_CLR = 2'd3;
endpackage

// File: rtl/bcp_regfile.sv
`timescale 1ns/1ps
module bcp_regfile
  import bcp_pkg::*;
#(
  parameter int NMOD  = 8,
  parameter int SEL_W = 3,
  localparam int FLD_W = SEL_W + 1,
  localparam int PRE_W = NDOM * FLD_W,
  localparam int RW    = (PRE_W > NMOD) ? PRE_W : NMOD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [RW-1:0]               reg_wdata,
  output logic [RW-1:0]               reg_rdata,
  output logic                        pll_sel,
  output logic [PRE_W-1:0]            presc,
  output logic [NDOM-1:0][NMOD-1:0]   mask,
  output logic                        err
);
  localparam int SH_W = SEL_W + 1;

  logic                      pll_sel_q;
  logic [PRE_W-1:0]          presc_q;
  logic [NDOM-1:0][NMOD-1:0] mask_q;
  logic                      err_q;
  logic                      wr_legal;
  logic [1:0]                mdom;

  function automatic logic [SH_W-1:0] fld_shift(input logic [FLD_W-1:0] f);
    return f[SEL_W] ? ({1'b0, f[SEL_W-1:0]} + SH_W'(1)) : '0;
  endfunction

  always_comb begin
    logic [NDOM-1:0][SH_W-1:0] sh;
    for (int d = 0; d < NDOM; d++) sh[d] = fld_shift(reg_wdata[d*FLD_W +: FLD_W]);
    wr_legal = (sh[DOM_CPU] <= sh[DOM_HSB]) &&
               (sh[DOM_HSB] <= sh[DOM_PBA]) &&
               (sh[DOM_HSB] <= sh[DOM_PBB]);
  end

  assign mdom = reg_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_sel_q <= 1'b0;
      presc_q   <= '0;
      mask_q    <= '0;
      err_q     <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_SRC) begin
        pll_sel_q <= reg_wdata[0];
      end else if (reg_addr == A_PRESC) begin
        if (wr_legal) presc_q <= reg_wdata[PRE_W-1:0];
        else          err_q   <= 1'b1;
      end else if (reg_addr == A_ERR) begin
        if (reg_wdata[0]) err_q <= 1'b0;
      end else begin
        case (reg_addr[3:2])
          MOP_WR:  mask_q[mdom] <= reg_wdata[NMOD-1:0];
          MOP_SET: mask_q[mdom] <= mask_q[mdom] | reg_wdata[NMOD-1:0];
          MOP_CLR: mask_q[mdom] <= mask_q[mdom] & ~reg_wdata[NMOD-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SRC)        reg_rdata = RW'(pll_sel_q);
    else if (reg_addr == A_PRESC) reg_rdata = RW'(presc_q);
    else if (reg_addr == A_ERR)   reg_rdata = RW'(err_q);
    else if (reg_addr == A_RSVD)  reg_rdata = '0;
    else                          reg_rdata = RW'(mask_q[mdom]);
  end

  assign pll_sel = pll_sel_q;
  assign presc   = presc_q;
  assign mask    = mask_q;
  assign err     = err_q;

  // R5
  refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable(presc_q));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(reg_we && reg_addr == A_ERR && reg_wdata[0])) |=> err_q);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(mask_q));
endmodule

// File: rtl/bcp_tickgen.sv
`timescale 1ns/1ps
module bcp_tickgen
  import bcp_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int FLD_W = SEL_W + 1,
  localparam int PRE_W = NDOM * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic [PRE_W-1:0] presc_pend,
  output logic [NDOM-1:0]  dom_tick
);
  localparam int SH_W  = SEL_W + 1;
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] act_q;
  logic             align;

  assign align = main_tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (main_tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (align) act_q <= presc_pend;
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [SH_W-1:0]  shift;
    logic [CNT_W-1:0] low_mask;
    assign shift    = act_q[d*FLD_W + SEL_W]
                    ? ({1'b0, act_q[d*FLD_W +: SEL_W]} + SH_W'(1)) : '0;
    assign low_mask = ~({CNT_W{1'b1}} << shift);
    assign dom_tick[d] = main_tick && ((cnt_q & low_mask) == '0);
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !align |=> $stable(act_q));

  // R10
  hsb_in_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_tick[DOM_HSB] |-> dom_tick[DOM_CPU]);

  // R10
  pba_in_hsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_tick[DOM_PBA] |-> dom_tick[DOM_HSB]);

  // R10
  pbb_in_hsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_tick[DOM_PBB] |-> dom_tick[DOM_HSB]);
endmodule

// File: rtl/bcp_gate.sv
`timescale 1ns/1ps
module bcp_gate
  import bcp_pkg::*;
#(
  parameter int NMOD = 8
) (
  input  logic [NDOM-1:0]           dom_tick,
  input  logic [NDOM-1:0][NMOD-1:0] mask,
  output logic [NDOM*NMOD-1:0]      mod_en
);
  for (genvar d = 0; d < NDOM; d++) begin : g_d
    for (genvar n = 0; n < NMOD; n++) begin : g_n
      assign mod_en[d*NMOD + n] = dom_tick[d] & mask[d][n];
    end
  end
endmodule

// File: rtl/busclk_prescaler.sv
`timescale 1ns/1ps
module busclk_prescaler
  import bcp_pkg::*;
#(
  parameter int NMOD  = 8,
  parameter int SEL_W = 3,
  localparam int FLD_W = SEL_W + 1,
  localparam int PRE_W = NDOM * FLD_W,
  localparam int RW    = (PRE_W > NMOD) ? PRE_W : NMOD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   osc_tick,
  input  logic                   pll_tick,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [RW-1:0]          reg_wdata,
  output logic [RW-1:0]          reg_rdata,
  output logic [NDOM-1:0]        dom_tick,
  output logic [NDOM*NMOD-1:0]   mod_en,
  output logic                   cfg_err
);
  logic                      pll_sel;
  logic [PRE_W-1:0]          presc;
  logic [NDOM-1:0][NMOD-1:0] mask;
  logic                      main_tick;

  bcp_regfile #(.NMOD(NMOD), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_sel(pll_sel),
    .presc(presc), .mask(mask), .err(cfg_err)
  );

  assign main_tick = pll_sel ? pll_tick : osc_tick;

  bcp_tickgen #(.SEL_W(SEL_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick),
    .presc_pend(presc), .dom_tick(dom_tick)
  );

  bcp_gate #(.NMOD(NMOD)) u_gate (
    .dom_tick(dom_tick), .mask(mask), .mod_en(mod_en)
  );

  // R2
  no_src_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_tick || pll_tick) |-> (dom_tick == '0));
endmodule

// File: tb/busclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module busclk_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0, pll_tick = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  dom_tick;
  logic [31:0] mod_en;
  logic        cfg_err;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag_ovr = "";

  // bench model state
  bit        m_pll, m_err;
  bit [15:0] m_pend, m_act;
  bit [7:0]  m_mask [4];
  bit [7:0]  m_cnt;

  always #5 clk = ~clk;

  busclk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dom_tick(dom_tick), .mod_en(mod_en), .cfg_err(cfg_err)
  );

  function automatic int shf(bit [15:0] v, int d);
    return v[4*d+3] ? int'(v[4*d +: 3]) + 1 : 0;
  endfunction

  function automatic bit legal(bit [15:0] v);
    return shf(v,0) <= shf(v,1) && shf(v,1) <= shf(v,2) && shf(v,1) <= shf(v,3);
  endfunction

  function automatic bit [3:0] exp_ticks(bit mt);
    bit [3:0] t;
    for (int d = 0; d < 4; d++)
      t[d] = mt && ((int'(m_cnt) % (1 << shf(m_act, d))) == 0);
    return t;
  endfunction

  function automatic bit [15:0] exp_rd(bit [3:0] a);
    if (a == 0) return {15'd0, m_pll};
    if (a == 1) return m_pend;
    if (a == 2) return {15'd0, m_err};
    if (a == 3) return 16'd0;
    return {8'd0, m_mask[a[1:0]]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pll = 0; m_err = 0; m_pend = 0; m_act = 0; m_cnt = 0;
    for (int d = 0; d < 4; d++) m_mask[d] = 0;
  endtask

  task automatic cyc(bit o, bit p, bit we, bit [3:0] a, bit [15:0] wd);
    bit mt;
    bit [3:0] et;
    bit [31:0] ee;
    @(negedge clk);
    osc_tick = o; pll_tick = p; reg_we = we; reg_addr = a; reg_wdata = wd;
    #4;
    mt = m_pll ? p : o;
    et = exp_ticks(mt);
    for (int d = 0; d < 4; d++)
      for (int n = 0; n < 8; n++) ee[8*d+n] = et[d] & m_mask[d][n];
    chk(m_pll ? "R2/R3/R4/R7 tick (pll)" : "R3/R4/R7 tick (osc)", dom_tick, et);
    chk("R9 module enables", mod_en, ee);
    chk("R10 ordering", ((dom_tick[1] & ~dom_tick[0]) | ((dom_tick[2] | dom_tick[3]) & ~dom_tick[1])), 0);
    chk((tag_ovr != "") ? tag_ovr : "R5/R6 err flag", cfg_err, m_err);
    chk((tag_ovr != "") ? tag_ovr :
        (a == 0) ? "R2 src rd" : (a == 1) ? "R5 presc rd" : (a == 2) ? "R6 err rd" : "R8 mask rd",
        reg_rdata, exp_rd(a));
    if (mt) begin
      if (m_cnt == 0) m_act = m_pend;
      m_cnt++;
    end
    if (we) begin
      case (a)
        0: m_pll = wd[0];
        1: if (legal(wd)) m_pend = wd; else m_err = 1;
        2: if (wd[0]) m_err = 0;
        3: ;
        default: case (a[3:2])
          1: m_mask[a[1:0]] = wd[7:0];
          2: m_mask[a[1:0]] |= wd[7:0];
          default: m_mask[a[1:0]] &= ~wd[7:0];
        endcase
      endcase
    end
  endtask

  task automatic wr(bit [3:0] a, bit [15:0] wd);
    cyc(0, 0, 1, a, wd);
  endtask

  task automatic run(int n, bit o, bit p);
    for (int i = 0; i < n; i++) cyc(o, p, 0, 4'(i % 16), 16'h0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state readback
    tag_ovr = "R1 reset state";
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, 4'(a), 16'h0);
    tag_ovr = "";
    // R3 undivided domains tick on every oscillator tick
    run(20, 1, 0);
    // R8 mask write / set / clear, R9 gating
    wr(4'd4, 16'h00A5);
    wr(4'd9, 16'h000F);
    wr(4'd13, 16'h0005);
    wr(4'd6, 16'h00FF);
    wr(4'd7, 16'h003C);
    wr(4'd3, 16'hFFFF);
    run(16, 1, 0);
    // R4 R7 legal divider setting, spans an alignment point
    wr(4'd1, 16'hA980);
    run(600, 1, 0);
    // R5 illegal ordering refused; R6 sticky and clear
    wr(4'd1, 16'hA98B);
    wr(4'd2, 16'h0000);
    run(10, 1, 0);
    wr(4'd2, 16'h0001);
    run(10, 1, 0);
    // R2 switch source to PLL
    wr(4'd0, 16'h0001);
    run(20, 1, 0);
    run(300, 0, 1);
    // R4 largest select on peripheral B
    wr(4'd1, 16'hF980);
    run(600, 0, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [3:0]  a = 4'($urandom_range(0, 15));
      bit [15:0] wd = 16'($urandom);
      bit        we = ($urandom_range(0, 9) == 0);
      if (a == 1 && $urandom_range(0, 1) == 1)
        wd = {1'b1, 3'($urandom_range(4,7)), 1'b1, 3'($urandom_range(2,3)),
              1'b1, 3'($urandom_range(0,1)), 1'b0, 3'($urandom)};
      if (a == 0) wd[0] = ($urandom_range(0, 3) != 0);
      cyc(($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0), we, a, wd);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule